// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 16-bit virtual word address, issued on behalf of one of 32 tasks, into a physical word address. It walks two levels of tables held in a shared word-addressed memory. The first level is a per-task root table indexed by the top five address bits. The second level is a user table indexed by the next five bits. Each entry is two 16-bit words. The first word holds the status flags and the frame number. The second word holds the swap location of the page.

A request is taken when `reqReady` is high. The walker reads both words of the root entry, then both words of the selected user entry, and on success returns `{frame, offset}` as the physical address. Every entry it finds valid gets its referenced flag written back. For a write request, the data-page entry also gets its dirty flag. When an entry is invalid, the walker stops and holds a fault report naming the level, the entry address and the swap fields. An external handler makes the page resident and pulses `retry`, and the lookup then runs again from the root. Addresses below a fixed limit pass straight through without any table access.

Top module: `vxlate_walker`

## Requirements
- R1: A request with a virtual address below BYPASS_LIMIT (default 0x3000) completes with `donePa` equal to the virtual address. It makes no memory access and raises neither `evHit` nor `evFault`.
- R2: A successful translation returns `donePa` = {user-entry frame bits 9:0, virtual address bits 5:0}.
- R3: The root entry's first word sits at ROOT_BASE + task*64 + 2*va[15:11], and its second word sits at the next address.
- R4: The user entry's first word sits at rootFrame*64 + 2*va[10:6], and its second word at the next address. Here rootFrame is bits 9:0 of the root entry's first word.
- R5: In an entry's first word, bit 15 marks it valid and bits 9:0 are the frame. In the second word, bit 15 is swap-valid and bits 11:0 are the swap page.
- R6: Each valid entry met gets its first word rewritten with bit 13 (referenced) set and all other bits kept. On a write request, the user entry also gets bit 14 (dirty) set. The root entry never gets bit 14 set by the walker. Second words are never written.
- R7: An invalid entry raises `faultValid`, which stays high until `retry`. While it is high, `faultLevel` (0 root, 1 user), `faultEntryAddr` (first-word address) and the swap fields of that entry are presented.
- R8: A `retry` pulse while faulted restarts the lookup from the root entry.
- R9: Each attempt pulses `evHit` once per valid entry plus once for the data access on success, and `evFault` once per invalid entry. This gives (hits, faults) of (0,1), (1,1) or (3,0).
- R10: After reset, `reqReady` is high and `done`, `faultValid` and `memEn` are low.
- R11: Memory reads have one cycle of latency. A successful attempt makes four reads and two writes, and `memWe` is only high together with `memEn`.
- R12: `reqReady` is high only while idle. It is low throughout a walk and while a fault is held, and nothing is accepted then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqReady | output | 1 | Walker idle, request accepted |
| reqVa | input | 16 | Virtual word address |
| reqWrite | input | 1 | Request is a write |
| reqTask | input | 5 | Task number |
| done | output | 1 | One-cycle completion pulse |
| donePa | output | 16 | Physical address, valid with done |
| faultValid | output | 1 | Fault held, waiting for retry |
| faultLevel | output | 1 | 0 root entry, 1 user entry |
| faultEntryAddr | output | 16 | Address of the faulting entry's first word |
| faultSwapValid | output | 1 | Swap-valid flag of the faulting entry |
| faultSwapPage | output | 12 | Swap page of the faulting entry |
| retry | input | 1 | Restart after a fault was serviced |
| evHit | output | 1 | Hit event pulse |
| evFault | output | 1 | Fault event pulse |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 16 | Memory word address |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Read data, one cycle after a read |

## Verification
The assertions assume that `retry` is only pulsed while a fault is held. They also assume that memory returns read data exactly one cycle after a read enable and that nothing else writes the port during a walk. The stimulus keeps to this: the bench changes table contents only while the walker is idle or faulted, and it pulses `retry` only after it has seen `faultValid`. Random requests mix pass-through and translated addresses, valid and invalid entries at both levels, and reads and writes. Root tables and user tables are placed in disjoint address ranges, so one request's entries never alias each other.

// File: rtl/vxlate_pkg.sv
package vxlate_pkg;

  // walker sequencing states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AIM,
    ST_RD0,
    ST_RD1,
    ST_CHK,
    ST_FAULT,
    ST_RESP
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch request fields
    logic aimRoot;    // point entry address at root entry
    logic aimUser;    // point entry address at user entry
    logic wordSel;    // 0 first word, 1 second word
    logic grabW0;     // latch read data as first word
    logic grabW1;     // latch read data as second word
    logic writeBack;  // write first word with status update
    logic atUser;     // current level is the user table
    logic setPa;      // load translated physical address
  } dpCtl_t;

  localparam int BIT_VALID = 15;
  localparam int BIT_DIRTY = 14;
  localparam int BIT_REF   = 13;
  localparam int BIT_SWAPV = 15;

endpackage

// File: rtl/vxlate_dpath.sv
module vxlate_dpath
  import vxlate_pkg::*;
#(
  parameter int VA_W         = 16,
  parameter int TASK_W       = 5,
  parameter int IDX_W        = 5,
  parameter int OFS_W        = 6,
  parameter int FRAME_W      = 10,
  parameter int SWAP_W       = 12,
  parameter int WORD_W       = 16,
  parameter logic [VA_W-1:0] ROOT_BASE    = 16'h2400,
  parameter logic [VA_W-1:0] BYPASS_LIMIT = 16'h3000
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [VA_W-1:0]    reqVa,
  input  logic               reqWrite,
  input  logic [TASK_W-1:0]  reqTask,
  input  logic [WORD_W-1:0]  memRdata,
  output logic [VA_W-1:0]    memAddr,
  output logic [WORD_W-1:0]  memWdata,
  output logic               isBypassReq,
  output logic               entryValid,
  output logic [VA_W-1:0]    pa,
  output logic [VA_W-1:0]    entryAddrOut,
  output logic               swapValidOut,
  output logic [SWAP_W-1:0]  swapPageOut
);

  localparam int TBL_WORDS = 2 * (1 << IDX_W);
  localparam int TBL_SH    = $clog2(TBL_WORDS);
  localparam int USR_LO    = VA_W - IDX_W - 1;

  logic [VA_W-1:0]   vaReg;
  logic [TASK_W-1:0] taskReg;
  logic              writeReg;
  logic [WORD_W-1:0] word0Reg;
  logic              swapVReg;
  logic [SWAP_W-1:0] swapPReg;
  logic [VA_W-1:0]   entryAddr;
  logic [VA_W-1:0]   paReg;

  logic [VA_W-1:0] taskOfs, rootIdxOfs, userIdxOfs, userBase;
  logic [VA_W-1:0] rootAddr, userAddr;
  logic [WORD_W-1:0] refMask, dirtyMask;

  assign taskOfs    = VA_W'(taskReg) << TBL_SH;
  assign rootIdxOfs = VA_W'(vaReg[VA_W-1 -: IDX_W]) << 1;
  assign userIdxOfs = VA_W'(vaReg[USR_LO -: IDX_W]) << 1;
  assign userBase   = VA_W'(word0Reg[FRAME_W-1:0]) << OFS_W;
  assign rootAddr   = ROOT_BASE + taskOfs + rootIdxOfs;
  assign userAddr   = userBase + userIdxOfs;

  assign refMask   = WORD_W'(1) << BIT_REF;
  assign dirtyMask = (ctl.atUser && writeReg) ? (WORD_W'(1) << BIT_DIRTY) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg     <= '0;
      taskReg   <= '0;
      writeReg  <= 1'b0;
      word0Reg  <= '0;
      swapVReg  <= 1'b0;
      swapPReg  <= '0;
      entryAddr <= '0;
      paReg     <= '0;
    end else begin
      if (ctl.capture) begin
        vaReg    <= reqVa;
        taskReg  <= reqTask;
        writeReg <= reqWrite;
        paReg    <= reqVa;
      end
      if (ctl.aimRoot) entryAddr <= rootAddr;
      if (ctl.aimUser) entryAddr <= userAddr;
      if (ctl.grabW0)  word0Reg  <= memRdata;
      if (ctl.grabW1) begin
        swapVReg <= memRdata[BIT_SWAPV];
        swapPReg <= memRdata[SWAP_W-1:0];
      end
      if (ctl.setPa) paReg <= {word0Reg[FRAME_W-1:0], vaReg[OFS_W-1:0]};
    end
  end

  assign isBypassReq  = (reqVa < BYPASS_LIMIT);
  assign entryValid   = word0Reg[BIT_VALID];
  assign memAddr      = entryAddr + VA_W'(ctl.wordSel);
  assign memWdata     = word0Reg | refMask | dirtyMask;
  assign pa           = paReg;
  assign entryAddrOut = entryAddr;
  assign swapValidOut = swapVReg;
  assign swapPageOut  = swapPReg;

  // R2: translated address keeps the in-page offset
  p_pa_offset_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.setPa |=> (pa[OFS_W-1:0] == vaReg[OFS_W-1:0]));

  // R6: root level write-back leaves the dirty flag as read
  p_root_clean_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.writeBack && !ctl.atUser) |-> (memWdata[BIT_DIRTY] == word0Reg[BIT_DIRTY]));

  // R6: write-back keeps the frame field
  p_keep_frame_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeBack |-> (memWdata[FRAME_W-1:0] == word0Reg[FRAME_W-1:0]));

  // R11: write-back only targets the first word of an entry
  p_wb_first_word_r11: assert property (@(posedge clk) disable iff (!rstN)
    ctl.writeBack |-> (memAddr == entryAddr));

endmodule

// File: rtl/vxlate_ctrl.sv
module vxlate_ctrl
  import vxlate_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   retry,
  input  logic   isBypassReq,
  input  logic   entryValid,
  output dpCtl_t ctl,
  output logic   reqReady,
  output logic   done,
  output logic   faultValid,
  output logic   faultLevel,
  output logic   evHit,
  output logic   evFault,
  output logic   memEn,
  output logic   memWe
);

  walkState_t state, nextState;
  logic atUserReg;
  logic passThru;

  always_comb begin
    nextState = state;
    ctl       = '0;
    ctl.atUser = atUserReg;
    reqReady  = 1'b0;
    done      = 1'b0;
    faultValid = 1'b0;
    evHit     = 1'b0;
    evFault   = 1'b0;
    memEn     = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.capture = 1'b1;
          nextState   = isBypassReq ? ST_RESP : ST_AIM;
        end
      end
      ST_AIM: begin
        ctl.aimRoot = 1'b1;
        nextState   = ST_RD0;
      end
      ST_RD0: begin
        memEn     = 1'b1;
        nextState = ST_RD1;
      end
      ST_RD1: begin
        memEn       = 1'b1;
        ctl.wordSel = 1'b1;
        ctl.grabW0  = 1'b1;
        nextState   = ST_CHK;
      end
      ST_CHK: begin
        ctl.grabW1 = 1'b1;
        if (entryValid) begin
          evHit         = 1'b1;
          memEn         = 1'b1;
          memWe         = 1'b1;
          ctl.writeBack = 1'b1;
          if (atUserReg) begin
            ctl.setPa = 1'b1;
            nextState = ST_RESP;
          end else begin
            ctl.aimUser = 1'b1;
            nextState   = ST_RD0;
          end
        end else begin
          evFault   = 1'b1;
          nextState = ST_FAULT;
        end
      end
      ST_FAULT: begin
        faultValid = 1'b1;
        if (retry) nextState = ST_AIM;
      end
      ST_RESP: begin
        done      = 1'b1;
        evHit     = !passThru;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      atUserReg <= 1'b0;
      passThru  <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.capture) passThru <= isBypassReq;
      if (state == ST_AIM) atUserReg <= 1'b0;
      if (ctl.aimUser) atUserReg <= 1'b1;
    end
  end

  assign faultLevel = atUserReg;

  // R7: fault report held until retry
  p_fault_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && !retry) |=> faultValid);

  // R8: retry leaves the fault state and restarts
  p_retry_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (faultValid && retry) |=> (!faultValid && !done && !reqReady));

  // R9: a single judgement per cycle
  p_one_event_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(evHit && evFault));

  // R11: write strobe only with enable
  p_we_with_en_r11: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memEn);

  // R12: idle walker leaves memory alone
  p_ready_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memEn && !faultValid));

endmodule

// File: rtl/vxlate_walker.sv
module vxlate_walker
  import vxlate_pkg::*;
#(
  parameter int VA_W    = 16,
  parameter int TASK_W  = 5,
  parameter int IDX_W   = 5,
  parameter int OFS_W   = 6,
  parameter int FRAME_W = 10,
  parameter int SWAP_W  = 12,
  parameter int WORD_W  = 16,
  parameter logic [VA_W-1:0] ROOT_BASE    = 16'h2400,
  parameter logic [VA_W-1:0] BYPASS_LIMIT = 16'h3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVa,
  input  logic              reqWrite,
  input  logic [TASK_W-1:0] reqTask,
  output logic              done,
  output logic [VA_W-1:0]   donePa,
  output logic              faultValid,
  output logic              faultLevel,
  output logic [VA_W-1:0]   faultEntryAddr,
  output logic              faultSwapValid,
  output logic [SWAP_W-1:0] faultSwapPage,
  input  logic              retry,
  output logic              evHit,
  output logic              evFault,
  output logic              memEn,
  output logic              memWe,
  output logic [VA_W-1:0]   memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata
);

  dpCtl_t ctl;
  logic   isBypassReq;
  logic   entryValid;

  vxlate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .retry      (retry),
    .isBypassReq(isBypassReq),
    .entryValid (entryValid),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .done       (done),
    .faultValid (faultValid),
    .faultLevel (faultLevel),
    .evHit      (evHit),
    .evFault    (evFault),
    .memEn      (memEn),
    .memWe      (memWe)
  );

  vxlate_dpath #(
    .VA_W        (VA_W),
    .TASK_W      (TASK_W),
    .IDX_W       (IDX_W),
    .OFS_W       (OFS_W),
    .FRAME_W     (FRAME_W),
    .SWAP_W      (SWAP_W),
    .WORD_W      (WORD_W),
    .ROOT_BASE   (ROOT_BASE),
    .BYPASS_LIMIT(BYPASS_LIMIT)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqVa       (reqVa),
    .reqWrite    (reqWrite),
    .reqTask     (reqTask),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memWdata    (memWdata),
    .isBypassReq (isBypassReq),
    .entryValid  (entryValid),
    .pa          (donePa),
    .entryAddrOut(faultEntryAddr),
    .swapValidOut(faultSwapValid),
    .swapPageOut (faultSwapPage)
  );

endmodule

// File: tb/sim_vxlate_walker.sv
module sim_vxlate_walker;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] RBASE = 16'h0400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, retry = 1'b0;
  logic [15:0] reqVa = '0;
  logic [4:0]  reqTask = '0;
  logic reqReady, done, faultValid, faultLevel, faultSwapValid;
  logic evHit, evFault, memEn, memWe;
  logic [15:0] donePa, faultEntryAddr, memAddr, memWdata;
  logic [11:0] faultSwapPage;
  logic [15:0] memRdata = '0;

  logic [15:0] mem [0:4095];
  logic        pokeEn = 1'b0;
  logic [11:0] pokeAddr = '0;
  logic [15:0] pokeData = '0;

  int nRun = 0, nFail = 0;
  int hitCnt, faultCnt, rdCnt, wrCnt;
  logic [15:0] lastPa;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe) mem[memAddr[11:0]] <= memWdata;
      else memRdata <= mem[memAddr[11:0]];
    end else if (pokeEn) begin
      mem[pokeAddr] <= pokeData;
    end
  end

  vxlate_walker #(.ROOT_BASE(RBASE)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVa(reqVa), .reqWrite(reqWrite), .reqTask(reqTask), .done(done),
    .donePa(donePa), .faultValid(faultValid), .faultLevel(faultLevel),
    .faultEntryAddr(faultEntryAddr), .faultSwapValid(faultSwapValid),
    .faultSwapPage(faultSwapPage), .retry(retry), .evHit(evHit),
    .evFault(evFault), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    pokeEn = 1'b1; pokeAddr = a[11:0]; pokeData = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  // waits for done or fault, counting events of this attempt
  task automatic waitEnd(output bit gotDone);
    hitCnt = 0; faultCnt = 0; rdCnt = 0; wrCnt = 0; gotDone = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      reqValid = 1'b0; retry = 1'b0;
      hitCnt   += int'(evHit);
      faultCnt += int'(evFault);
      rdCnt    += int'(memEn && !memWe);
      wrCnt    += int'(memEn && memWe);
      if (done) begin gotDone = 1; lastPa = donePa; return; end
      if (faultValid) return;
    end
    chk("R12 walk stalled", 1, 0);
  endtask

  task automatic issue(input logic [15:0] va, input bit wr, input logic [4:0] tk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqVa = va; reqWrite = wr; reqTask = tk;
  endtask

  task automatic checkFault(input string lvlTag, input bit lvl, input logic [15:0] ea,
                            input logic [15:0] w1);
    chk({lvlTag, " level"}, faultLevel, lvl);
    chk({lvlTag, " entry address"}, faultEntryAddr, ea);
    chk("R5 swap valid", faultSwapValid, w1[15]);
    chk("R5 swap page", faultSwapPage, w1[11:0]);
    chk("R9 fault attempt hits", hitCnt, lvl ? 1 : 0);
    chk("R9 fault attempt faults", faultCnt, 1);
    repeat (3) @(negedge clk);
    chk("R7 fault held", faultValid, 1);
    chk("R12 not ready while faulted", reqReady, 0);
  endtask

  task automatic runCase(input logic [15:0] va, input bit wr, input logic [4:0] tk,
                         input logic [15:0] r0, input logic [15:0] r1,
                         input logic [15:0] u0, input logic [15:0] u1,
                         input logic [9:0] fixRoot, input logic [9:0] fixUser);
    bit gotDone;
    logic [15:0] rA, uA, rCur, uCur, expW;
    logic [9:0] rFrame;
    if (va < 16'h3000) begin
      issue(va, wr, tk);
      waitEnd(gotDone);
      chk("R1 bypass completes", gotDone, 1);
      chk("R1 bypass address", lastPa, va);
      chk("R1 bypass no access", rdCnt + wrCnt, 0);
      chk("R1 bypass no events", hitCnt + faultCnt, 0);
      return;
    end
    rA = RBASE + 16'(tk) * 16'd64 + 16'(va[15:11]) * 16'd2;
    rFrame = r0[15] ? r0[9:0] : fixRoot;
    uA = 16'(rFrame) * 16'd64 + 16'(va[10:6]) * 16'd2;
    poke(rA, r0); poke(rA + 16'd1, r1);
    poke(uA, u0); poke(uA + 16'd1, u1);
    rCur = r0; uCur = u0;
    issue(va, wr, tk);
    waitEnd(gotDone);
    if (!r0[15]) begin
      chk("R7 root fault raised", faultValid, 1);
      checkFault("R3", 1'b0, rA, r1);
      rCur = 16'h8000 | 16'(fixRoot);
      poke(rA, rCur);
      retry = 1'b1;
      waitEnd(gotDone);
    end
    if (!u0[15]) begin
      chk("R7 user fault raised", faultValid, 1);
      checkFault("R4", 1'b1, uA, u1);
      uCur = 16'h8000 | 16'(fixUser);
      poke(uA, uCur);
      retry = 1'b1;
      waitEnd(gotDone);
    end
    chk("R8 completes after retries", gotDone, 1);
    chk("R2 physical address", lastPa, {uCur[9:0], va[5:0]});
    chk("R9 success hits", hitCnt, 3);
    chk("R9 success faults", faultCnt, 0);
    chk("R11 reads per attempt", rdCnt, 4);
    chk("R11 writes per attempt", wrCnt, 2);
    @(negedge clk);
    chk("R12 ready after done", reqReady, 1);
    chk("R6 root word0", mem[rA[11:0]], rCur | 16'h2000);
    chk("R6 root word1 untouched", mem[rA[11:0] + 12'd1], r1);
    expW = uCur | 16'h2000 | (wr ? 16'h4000 : 16'h0000);
    chk("R6 user word0", mem[uA[11:0]], expW);
    chk("R6 user word1 untouched", mem[uA[11:0] + 12'd1], u1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd1357);
    repeat (3) @(negedge clk);
    chk("R10 ready in reset", reqReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", reqReady, 1);
    chk("R10 no done", done, 0);
    chk("R10 no fault", faultValid, 0);
    chk("R10 no memory enable", memEn, 0);

    // directed corners
    runCase(16'h2FFF, 1'b1, 5'd3, 0, 0, 0, 0, 10'h030, 10'h000);
    runCase(16'h0000, 1'b0, 5'd0, 0, 0, 0, 0, 10'h030, 10'h000);
    runCase(16'h3000, 1'b0, 5'd0, 16'h8031, 16'h0000, 16'h8005, 16'h0000, 10'h030, 10'h000);
    runCase(16'hFFFF, 1'b1, 5'd31, 16'h903F, 16'h8ABC, 16'h83FF, 16'h0123, 10'h030, 10'h000);
    runCase(16'h7A5C, 1'b1, 5'd9, 16'h0000, 16'h8FFF, 16'h0000, 16'h8001, 10'h03A, 10'h155);
    runCase(16'hC3C3, 1'b0, 5'd17, 16'h6032, 16'h0000, 16'h4111, 16'h7FFF, 10'h033, 10'h2AA);

    for (int n = 0; n < 300; n++) begin
      logic [15:0] va, r0, r1, u0, u1;
      logic [9:0] fr, fu;
      bit wr, rv, uv;
      logic [4:0] tk;
      tk = 5'($urandom % 32);
      wr = 1'($urandom);
      if ($urandom % 8 == 0) va = 16'($urandom % 16'h3000);
      else va = 16'h3000 + 16'($urandom % 16'hD000);
      rv = ($urandom % 4) != 0;
      uv = ($urandom % 4) != 0;
      fr = 10'h030 + 10'($urandom % 16);
      fu = 10'($urandom);
      r0 = (16'($urandom) & 16'h7000) | (rv ? (16'h8000 | 16'(fr)) : (16'($urandom) & 16'h03FF));
      r1 = 16'($urandom);
      u0 = (16'($urandom) & 16'h7000) | (uv ? 16'h8000 : 16'h0000) | (16'($urandom) & 16'h03FF);
      u1 = 16'($urandom);
      runCase(va, wr, tk, r0, r1, u0, u1, 10'h030 + 10'($urandom % 16), fu);
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule